// File: doc/BRIEF.md
# Shadowed Nonvolatile SRAM Store Controller

This block sits in front of a working SRAM and a nonvolatile shadow array of the same size. Both arrays are modelled here as on-chip register arrays. Software sees a byte-wide read/write port. The shadow array receives the whole SRAM image only when a store runs. A store has three possible triggers: an active-low hardware store request, a power-fail detect input (automatic store), and a software store command. After reset, the block copies the shadow array back into the SRAM before it accepts any access.

An internal write latch records whether the SRAM was written since the last store or recall. Hardware and automatic stores are skipped while that latch is clear, which avoids needless wear on the shadow array. Automatic store is switched on and off by a fixed run of reads, and that run never sets the latch. Every store first erases the whole shadow array and then copies every SRAM byte, one address per clock. A counter tracks completed stores for endurance accounting.

Top module: `nvsram_store_ctrl`

## Requirements
- R1: While `rst_n` is low, `busy_n` is low and `store_count` is zero. After release, the block recalls the whole shadow array into the SRAM, which holds `busy_n` low for exactly 2^ADDR_W cycles. Then `busy_n` goes high.
- R2: While `busy_n` is high, `acc_en` with `acc_we`=1 writes `acc_wdata` at `acc_addr`. `acc_en` with `acc_we`=0 returns the stored byte on `rd_data` with `rd_valid` high, one clock after the request edge.
- R3: Only an accepted write sets the write latch. Reads, including every command sequence, leave it unchanged.
- R4: A cycle with `hw_store_n` low while idle starts a store if the write latch is set. If the latch is clear, no store starts.
- R5: A store holds `busy_n` low for exactly 2·2^ADDR_W cycles: an erase walk, then a copy walk of every address. It then clears the write latch and adds one to `store_count`.
- R6: A command is six reads. The first five are at 0x05, 0x12, 0x1F, 0x2C, 0x39. The sixth selects the command: 0x06 software store, 0x07 automatic store off, 0x08 automatic store on. A read off the expected address restarts the matcher at step one. Reads in a sequence return normal data.
- R7: A software store command starts a store whether or not the write latch is set.
- R8: A `pwr_fail` cycle while idle starts a store only when automatic store is on and the write latch is set. Automatic store is on after reset.
- R9: Only completed stores change `store_count`. Reads, writes and command sequences do not.
- R10: While `busy_n` is low, access requests are ignored: no `rd_valid` and no SRAM update.
- R11: After a reset-time recall, the SRAM holds the image of the last completed store, and the write latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts the recall |
| acc_en | input | 1 | Access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address |
| acc_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data |
| rd_valid | output | 1 | Read data valid |
| hw_store_n | input | 1 | Active-low hardware store request |
| pwr_fail | input | 1 | Power-fail detect, requests an automatic store |
| busy_n | output | 1 | Low during recall or store |
| store_count | output | CNT_W | Completed store cycles |

## Verification
Some rules are checked on every clock by the assertions:
- the write latch follows accepted writes only;
- a hardware request with the latch clear leaves the engine idle;
- the store counter moves only at the end of a copy walk;
- the enable state changes only after a read;
- requests made while busy produce no read data.

Other properties only the bench scenarios can show. These are the exact busy lengths, that the whole image survives a reset through the shadow array, and that writes dropped while busy never reach the SRAM. The same holds for the end-to-end gating of power-fail stores by the enable sequences.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   typedef enum logic [1:0] {
      ST_RECALL = 2'd0,
      ST_IDLE   = 2'd1,
      ST_ERASE  = 2'd2,
      ST_COPY   = 2'd3
   } eng_state_e;

   localparam int SEQ_PREFIX_LEN = 5;

   localparam logic [5:0] TAIL_STORE    = 6'h06;
   localparam logic [5:0] TAIL_AUTO_OFF = 6'h07;
   localparam logic [5:0] TAIL_AUTO_ON  = 6'h08;

   // Address expected at prefix step k of a command sequence
   function automatic logic [5:0] prefix_addr(input int step);
      return 6'((step * 13 + 5) % 64);
   endfunction

endpackage

// File: rtl/nvs_regarray.sv
module nvs_regarray #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_data;
   end

   assign rd_data = cells[rd_addr];

endmodule

// File: rtl/nvs_seq_match.sv
module nvs_seq_match
   import nvs_pkg::*;
#(
   parameter int   ADDR_W       = 6,
   parameter logic AUTO_DEFAULT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  logic [ADDR_W-1:0] addr,
   output logic              sw_store,
   output logic              auto_en
);

   logic [2:0]        step;
   logic [ADDR_W-1:0] want;
   logic              hit_prefix;

   assign want       = ADDR_W'(prefix_addr(int'(step)));
   assign hit_prefix = (addr == want);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step     <= '0;
         sw_store <= 1'b0;
         auto_en  <= AUTO_DEFAULT;
      end else begin
         sw_store <= 1'b0;
         if (rd_fire) begin
            if (int'(step) < SEQ_PREFIX_LEN) begin
               step <= hit_prefix ? step + 3'd1 : 3'd0;
            end else begin
               step <= 3'd0;
               if (addr == ADDR_W'(TAIL_STORE))         sw_store <= 1'b1;
               else if (addr == ADDR_W'(TAIL_AUTO_OFF)) auto_en  <= 1'b0;
               else if (addr == ADDR_W'(TAIL_AUTO_ON))  auto_en  <= 1'b1;
            end
         end
      end
   end

   assert_auto_by_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en != $past(auto_en)) |-> $past(rd_fire));

   assert_cmd_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sw_store |-> $past(rd_fire));

endmodule

// File: rtl/nvs_engine.sv
module nvs_engine
   import nvs_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic              hw_store_n,
   input  logic              pwr_fail,
   input  logic              auto_en,
   input  logic              sw_store,
   output eng_state_e        st,
   output logic [ADDR_W-1:0] idx,
   output logic              wl,
   output logic [CNT_W-1:0]  cnt
);

   logic last, start;

   assign last  = (idx == '1);
   assign start = (!hw_store_n && wl) || (pwr_fail && auto_en && wl) || sw_store;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_RECALL;
         idx <= '0;
         wl  <= 1'b0;
         cnt <= '0;
      end else begin
         unique case (st)
            ST_RECALL: begin
               idx <= idx + 1'b1;
               if (last) begin
                  st  <= ST_IDLE;
                  wl  <= 1'b0;
                  idx <= '0;
               end
            end
            ST_IDLE: begin
               if (wr_fire) wl <= 1'b1;
               if (start) begin
                  st  <= ST_ERASE;
                  idx <= '0;
               end
            end
            ST_ERASE: begin
               idx <= idx + 1'b1;
               if (last) begin
                  st  <= ST_COPY;
                  idx <= '0;
               end
            end
            ST_COPY: begin
               idx <= idx + 1'b1;
               if (last) begin
                  st  <= ST_IDLE;
                  idx <= '0;
                  wl  <= 1'b0;
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assert_write_sets_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && wr_fire) |=> wl);

   assert_read_keeps_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !wl && !wr_fire) |=> !wl);

   assert_hw_clear_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !wl && !sw_store) |=> (st == ST_IDLE));

   assert_count_on_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> ($past(st) == ST_COPY));

   assert_recall_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_RECALL && st == ST_IDLE) |-> !wl);

endmodule

// File: rtl/nvsram_store_ctrl.sv
module nvsram_store_ctrl
   import nvs_pkg::*;
#(
   parameter int   ADDR_W       = 6,
   parameter int   DATA_W       = 8,
   parameter int   CNT_W        = 16,
   parameter logic AUTO_DEFAULT = 1'b1,
   parameter logic ERASED_ONES  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic              hw_store_n,
   input  logic              pwr_fail,
   output logic              busy_n,
   output logic [CNT_W-1:0]  store_count
);

   generate
      if (ADDR_W < 6)  begin : g_chk_small  $error("ADDR_W must be at least 6"); end
      if (ADDR_W > 12) begin : g_chk_large  $error("ADDR_W must be at most 12"); end
      if (DATA_W < 1)  begin : g_chk_data   $error("DATA_W must be positive"); end
      if (CNT_W < 1)   begin : g_chk_cnt    $error("CNT_W must be positive"); end
   endgenerate

   eng_state_e        st;
   logic [ADDR_W-1:0] idx;
   logic              wl, idle, rd_fire, wr_fire, sw_store, auto_en;
   logic [DATA_W-1:0] erase_word, sram_rd, shadow_rd;
   logic              sram_we, shadow_we;
   logic [ADDR_W-1:0] sram_waddr, sram_raddr;
   logic [DATA_W-1:0] sram_wdata, shadow_wdata;

   generate
      if (ERASED_ONES) begin : g_erase_ones
         assign erase_word = '1;
      end else begin : g_erase_zero
         assign erase_word = '0;
      end
   endgenerate

   assign idle    = (st == ST_IDLE);
   assign busy_n  = idle;
   assign rd_fire = acc_en && !acc_we && idle;
   assign wr_fire = acc_en &&  acc_we && idle;

   assign sram_we      = wr_fire || (st == ST_RECALL);
   assign sram_waddr   = (st == ST_RECALL) ? idx : acc_addr;
   assign sram_wdata   = (st == ST_RECALL) ? shadow_rd : acc_wdata;
   assign sram_raddr   = idle ? acc_addr : idx;
   assign shadow_we    = (st == ST_ERASE) || (st == ST_COPY);
   assign shadow_wdata = (st == ST_ERASE) ? erase_word : sram_rd;

   nvs_regarray #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) sram_i (
      .clk(clk), .wr_en(sram_we), .wr_addr(sram_waddr), .wr_data(sram_wdata),
      .rd_addr(sram_raddr), .rd_data(sram_rd)
   );

   nvs_regarray #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) shadow_i (
      .clk(clk), .wr_en(shadow_we), .wr_addr(idx), .wr_data(shadow_wdata),
      .rd_addr(idx), .rd_data(shadow_rd)
   );

   nvs_seq_match #(.ADDR_W(ADDR_W), .AUTO_DEFAULT(AUTO_DEFAULT)) match_i (
      .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .addr(acc_addr),
      .sw_store(sw_store), .auto_en(auto_en)
   );

   nvs_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) engine_i (
      .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .hw_store_n(hw_store_n),
      .pwr_fail(pwr_fail), .auto_en(auto_en), .sw_store(sw_store),
      .st(st), .idx(idx), .wl(wl), .cnt(store_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_fire;
         if (rd_fire) rd_data <= sram_rd;
      end
   end

   assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_n && acc_en) |=> !rd_valid);

   assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_n && acc_en && !acc_we) |=> rd_valid);

endmodule

// File: tb/nvsram_store_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvsram_store_ctrl_tb_top;

   localparam int AW = 6;
   localparam int DW = 8;
   localparam int CW = 16;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          acc_en = 1'b0, acc_we = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [DW-1:0] acc_wdata = '0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic          hw_store_n = 1'b1, pwr_fail = 1'b0;
   logic          busy_n;
   logic [CW-1:0] store_count;

   nvsram_store_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
      .rd_valid(rd_valid), .hw_store_n(hw_store_n), .pwr_fail(pwr_fail),
      .busy_n(busy_n), .store_count(store_count)
   );

   int n_chk = 0, n_fail = 0;
   logic [DW-1:0] m_sram [DEPTH];
   logic [DW-1:0] m_shadow [DEPTH];
   int m_cnt = 0;
   logic [DW-1:0] exp_q [$];
   string         tag_q [$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard as read data appears
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R10 unexpected read data", int'(rd_data), 0);
         end else begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rd_data == e, t, int'(rd_data), int'(e));
         end
      end
   end

   task automatic do_write(input int a, input logic [DW-1:0] d);
      acc_en = 1'b1; acc_we = 1'b1; acc_addr = AW'(a); acc_wdata = d;
      @(negedge clk);
      acc_en = 1'b0; acc_we = 1'b0;
      m_sram[a] = d;
   endtask

   task automatic do_read(input int a, input string tag);
      acc_en = 1'b1; acc_we = 1'b0; acc_addr = AW'(a);
      exp_q.push_back(m_sram[a]);
      tag_q.push_back(tag);
      @(negedge clk);
      acc_en = 1'b0;
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (!busy_n && cyc < 1000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic hw_pulse();
      hw_store_n = 1'b0;
      @(negedge clk);
      hw_store_n = 1'b1;
   endtask

   task automatic pf_pulse();
      pwr_fail = 1'b1;
      @(negedge clk);
      pwr_fail = 1'b0;
   endtask

   task automatic expect_store(input string tag);
      int cyc;
      chk(busy_n == 1'b0, {tag, " store started"}, int'(busy_n), 0);
      wait_idle(cyc);
      chk(cyc == 2 * DEPTH, "R5 store busy length", cyc, 2 * DEPTH);
      m_cnt++;
      for (int i = 0; i < DEPTH; i++) m_shadow[i] = m_sram[i];
      chk(int'(store_count) == m_cnt, {tag, " R5 count after store"}, int'(store_count), m_cnt);
   endtask

   task automatic expect_no_store(input string tag);
      bit stayed = 1'b1;
      for (int i = 0; i < 4; i++) begin
         if (!busy_n) stayed = 1'b0;
         @(negedge clk);
      end
      chk(stayed, {tag, " no store"}, int'(stayed), 1);
      chk(int'(store_count) == m_cnt, {tag, " R9 count unchanged"}, int'(store_count), m_cnt);
   endtask

   task automatic run_seq(input int tail, input string tag);
      for (int k = 0; k < 5; k++) do_read((k * 13 + 5) % 64, tag);
      do_read(tail, tag);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int cyc;
      // R1: reset state and recall length
      repeat (3) @(negedge clk);
      chk(busy_n == 1'b0, "R1 busy_n low in reset", int'(busy_n), 0);
      chk(store_count == '0, "R1 count zero in reset", int'(store_count), 0);
      rst_n = 1'b1;
      wait_idle(cyc);
      chk(cyc == DEPTH, "R1 recall length", cyc, DEPTH);

      // R2: write whole array, read it back
      for (int i = 0; i < DEPTH; i++) do_write(i, DW'(i * 7 + 3));
      for (int i = 0; i < DEPTH; i++) do_read(i, "R2 readback");
      @(negedge clk);

      // R4/R5: hardware store with latch set
      hw_pulse();
      expect_store("R4 hw store");
      // R4: latch now clear, request ignored
      hw_pulse();
      expect_no_store("R4 latch clear");

      // R6/R3: auto-off sequence is reads only, latch stays clear
      run_seq(7, "R6 seq read data");
      hw_pulse();
      expect_no_store("R3 sequence leaves latch clear");

      // R8: auto store off, power fail ignored; hardware store still works
      do_write(10, 8'h11);
      pf_pulse();
      expect_no_store("R8 auto off");
      hw_pulse();
      expect_store("R4 hw store auto off");

      // R8: auto store on
      run_seq(8, "R6 seq read data");
      do_write(11, 8'h22);
      pf_pulse();
      expect_store("R8 power fail store");
      pf_pulse();
      expect_no_store("R8 latch clear");

      // R7: software store with latch clear
      run_seq(6, "R7 seq read data");
      expect_store("R7 sw store");

      // R6: broken sequence restarts matcher
      do_read(5, "R6 broken"); do_read(18, "R6 broken"); do_read(0, "R6 broken");
      do_read(44, "R6 broken"); do_read(57, "R6 broken"); do_read(6, "R6 broken");
      @(negedge clk);
      expect_no_store("R6 broken sequence");

      // R10: accesses while busy are dropped
      do_write(3, 8'h5A);
      hw_pulse();
      acc_en = 1'b1; acc_we = 1'b1; acc_addr = AW'(0); acc_wdata = 8'hAA;
      @(negedge clk);
      acc_we = 1'b0; acc_addr = AW'(1);
      @(negedge clk);
      acc_en = 1'b0;
      wait_idle(cyc);
      m_cnt++;
      for (int i = 0; i < DEPTH; i++) m_shadow[i] = m_sram[i];
      chk(int'(store_count) == m_cnt, "R10 store count", int'(store_count), m_cnt);
      do_read(0, "R10 write dropped while busy");
      @(negedge clk);

      // R11: unsaved write lost over reset, recall restores last store
      do_write(20, 8'hEE);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      wait_idle(cyc);
      chk(cyc == DEPTH, "R1 recall length after power cycle", cyc, DEPTH);
      m_cnt = 0;
      for (int i = 0; i < DEPTH; i++) m_sram[i] = m_shadow[i];
      for (int i = 0; i < DEPTH; i++) do_read(i, "R11 recalled data");
      @(negedge clk);
      hw_pulse();
      expect_no_store("R11 latch clear after recall");

      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end

endmodule